// File: doc/BRIEF.md
# Packet-Interface Task-File Controller

This block is the device side of a packet-protocol disk interface. It holds the host-visible task-file registers (data port, error/feature, interrupt reason, address low, byte count low and high, status/command and alternate-status/control) and the small state machine behind them. A host issues the packet command, pushes a twelve-byte command packet through the 16-bit data port, and the controller hands that packet to an external packet decoder. When the decoder has placed a response in the local read buffer, it asks the controller to start a programmed-I/O read of N bytes, and the host then drains the buffer one word per data-port read.

The controller also owns the pending-interrupt flag. Completion events set it, command writes clear it, and a status read clears it only when the device is not busy. A mask bit in the control register gates it onto the interrupt pin. Packet meaning, DMA transfers and sector fetching are not part of this block.

The host side is a plain one-access-per-cycle register port. Read data is combinational from the current register state, and the side effects of a read take place at the clock edge that ends the access. The two streams to the decoder are valid/ready. The packet stream holds `pkt_valid` and `pkt_data` steady until `pkt_ready` is seen. The read-start stream accepts `rd_len` only in a cycle where `rd_ready` and `rd_valid` are both high. The decoder may hold `rd_valid` for as long as it likes, and `rd_len` must be stable while it waits.

Top module: `pkt_taskfile_ctrl`

## Requirements
- R1: After reset the address-low register reads 0x81, byte-count low 0x14, byte-count high 0xEB, error 0x01, interrupt reason 0x01, status 0x00; the interrupt pin is low and a data-port read returns 0xFFFF.
- R2: Register addresses: 0 data port, 1 error (read) / feature (write), 2 interrupt reason, 3 address low, 4 byte-count low, 5 byte-count high, 7 status (read) / command (write), 8 alternate status (read) / control (write); any other address reads 0.
- R3: Command 0xA0 enters command-write: status 0x58, error = feature bits 1:0, interrupt reason 0x01 (command/data bit 0 set), and six data-port writes are expected.
- R4: Each command-write data word is stored at the next word slot. After the sixth word the status becomes 0xD0 (BSY set, DRQ clear) and `pkt_valid` rises with word k on `pkt_data[16k+15:16k]`. Data-port writes outside command-write are ignored.
- R5: `pkt_valid` and `pkt_data` hold until `pkt_ready`. `rd_ready` is high only in the busy state, with no packet still offered and no command write in that cycle.
- R6: An accepted read start sets interrupt reason 0x02 (I/O bit 1), status 0x58, byte-count low/high to `rd_len`, and raises the interrupt.
- R7: In PIO-read each data-port read returns the next buffer word. The read that reaches `rd_len` bytes returns to idle with status 0x50, interrupt reason 0x03, and raises the interrupt.
- R8: A status read (address 7) clears the pending interrupt only when BSY is clear. An alternate-status read (address 8) never clears it.
- R9: The interrupt pin is the pending flag masked by control bit 1 (1 = masked). A control write takes effect at the edge that ends the write, without touching the pending flag.
- R10: Every command write first clears the pending interrupt. A command other than 0x00, 0xA0 or 0xEF changes nothing else.
- R11: Command 0x00 aborts any transfer: idle state, status 0x51, error 0x04, interrupt raised, and any offered packet withdrawn.
- R12: Command 0xEF completes at once: status 0x50, error 0x00, both byte-count registers 0x00, interrupt raised. Raising an already pending interrupt has no further effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | Host register access this cycle |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 4 | Register address |
| host_wdata | input | 16 | Write data (8-bit registers use bits 7:0) |
| host_rdata | output | 16 | Read data for the current access |
| irq | output | 1 | Masked interrupt request |
| pkt_valid | output | 1 | Command packet offered to decoder |
| pkt_ready | input | 1 | Decoder takes the packet |
| pkt_data | output | 96 | Packet, word k at bits 16k+15:16k |
| rd_valid | input | 1 | Decoder requests a PIO read |
| rd_ready | output | 1 | Read start can be accepted |
| rd_len | input | 9 | Read length in bytes |
| buf_we | input | 1 | Read-buffer word write enable |
| buf_waddr | input | 7 | Read-buffer word address |
| buf_wdata | input | 16 | Read-buffer word data |

## Verification
The bench goes after the exact end of each transfer. A design that is one word off would either drop DRQ a word early or offer the packet before the sixth word arrives, so the intermediate status and packet valid are checked before the final word. It exercises interrupt clearing from several directions: alternate-status reads that must not clear, command writes of unknown codes that must clear but change nothing else, and the mask being toggled with a flag pending. A design that tied clearing to any status-port access, or that folded the mask into the flag, would lose the interrupt. It also runs a 256-byte read, so that a byte-count high register truncated to the low byte, or a length counter one bit too narrow, shows up. It aborts a read midway with the no-operation command, which must bring data reads back to 0xFFFF.

// File: rtl/ptf_pkg.sv
package ptf_pkg;
  typedef enum logic [1:0] {
    PS_IDLE = 2'd0,
    PS_CMDW = 2'd1,
    PS_PIO  = 2'd2,
    PS_BUSY = 2'd3
  } ptf_state_e;

  localparam logic [3:0] RA_DATA   = 4'd0;
  localparam logic [3:0] RA_ERRFT  = 4'd1;
  localparam logic [3:0] RA_REASON = 4'd2;
  localparam logic [3:0] RA_ADRLO  = 4'd3;
  localparam logic [3:0] RA_BCLO   = 4'd4;
  localparam logic [3:0] RA_BCHI   = 4'd5;
  localparam logic [3:0] RA_STCMD  = 4'd7;
  localparam logic [3:0] RA_ALTCTL = 4'd8;

  localparam logic [7:0] OP_NOP    = 8'h00;
  localparam logic [7:0] OP_PACKET = 8'hA0;
  localparam logic [7:0] OP_SETFT  = 8'hEF;

  localparam logic [7:0] ST_BSY = 8'h80;
  localparam logic [7:0] ST_DRQ = 8'h08;
  localparam logic [7:0] ST_XFER  = 8'h58;
  localparam logic [7:0] ST_DONE  = 8'h50;
  localparam logic [7:0] ST_ABORT = 8'h51;

  localparam logic [7:0] RSN_CMD  = 8'h01;
  localparam logic [7:0] RSN_IO   = 8'h02;
  localparam logic [7:0] RSN_DONE = 8'h03;
endpackage

// File: rtl/ptf_irq.sv
module ptf_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic raise,
  input  logic clear,
  input  logic masked,
  output logic pending,
  output logic irq_o
);
  logic pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      pend_q <= 1'b0;
    else if (raise)  pend_q <= 1'b1;
    else if (clear)  pend_q <= 1'b0;
  end

  assign pending = pend_q;
  assign irq_o   = pend_q & ~masked;
endmodule

// File: rtl/ptf_pkt_capture.sv
module ptf_pkt_capture #(
  parameter int PKT_WORDS = 6,
  parameter int IDX_W     = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       wr_idx,
  input  logic [15:0]            wr_word,
  input  logic                   launch,
  input  logic                   drop,
  input  logic                   ready,
  output logic                   valid,
  output logic [PKT_WORDS*16-1:0] data
);
  logic valid_q;

  for (genvar k = 0; k < PKT_WORDS; k++) begin : g_slot
    logic [15:0] word_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                                 word_q <= '0;
      else if (wr_en && wr_idx == IDX_W'(k))      word_q <= wr_word;
    end
    assign data[16*k +: 16] = word_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)               valid_q <= 1'b0;
    else if (drop)            valid_q <= 1'b0;
    else if (launch)          valid_q <= 1'b1;
    else if (valid_q && ready) valid_q <= 1'b0;
  end

  assign valid = valid_q;
endmodule

// File: rtl/ptf_rd_buffer.sv
module ptf_rd_buffer #(
  parameter int WORDS = 128,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [15:0]   wdata,
  input  logic [AW-1:0] raddr,
  output logic [15:0]   rdata
);
  logic [15:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/pkt_taskfile_ctrl.sv
module pkt_taskfile_ctrl
  import ptf_pkg::*;
#(
  parameter int BUF_WORDS = 128,
  parameter int PKT_BYTES = 12,
  localparam int AW       = $clog2(BUF_WORDS),
  localparam int LEN_W    = AW + 2,
  localparam int PKT_W    = PKT_BYTES * 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_sel,
  input  logic             host_wr,
  input  logic [3:0]       host_addr,
  input  logic [15:0]      host_wdata,
  output logic [15:0]      host_rdata,
  output logic             irq,
  output logic             pkt_valid,
  input  logic             pkt_ready,
  output logic [PKT_W-1:0] pkt_data,
  input  logic             rd_valid,
  output logic             rd_ready,
  input  logic [LEN_W-1:0] rd_len,
  input  logic             buf_we,
  input  logic [AW-1:0]    buf_waddr,
  input  logic [15:0]      buf_wdata
);
  localparam int PKT_WORDS = PKT_BYTES / 2;
  localparam int WO_W      = AW + 1;

  ptf_state_e       state_q;
  logic [7:0]       status_q, error_q, reason_q, adrlo_q, bclo_q, bchi_q;
  logic [1:0]       feat_q;
  logic             nien_q;
  logic [WO_W-1:0]  wofs_q;
  logic [LEN_W-1:0] len_q;
  logic             pending;
  logic [15:0]      buf_rword;
  logic [15:0]      len_ext;

  // Host access decode
  logic acc_rd, acc_wr, data_rd, data_wr, cmd_wr, stat_rd;
  logic op_nop, op_pkt, op_setft;
  logic pkt_word, pkt_last, pio_word, pio_last, rd_take;
  logic [WO_W:0] wnext;

  assign acc_rd   = host_sel & ~host_wr;
  assign acc_wr   = host_sel &  host_wr;
  assign data_rd  = acc_rd & (host_addr == RA_DATA);
  assign data_wr  = acc_wr & (host_addr == RA_DATA);
  assign cmd_wr   = acc_wr & (host_addr == RA_STCMD);
  assign stat_rd  = acc_rd & (host_addr == RA_STCMD);
  assign op_nop   = cmd_wr & (host_wdata[7:0] == OP_NOP);
  assign op_pkt   = cmd_wr & (host_wdata[7:0] == OP_PACKET);
  assign op_setft = cmd_wr & (host_wdata[7:0] == OP_SETFT);

  assign wnext    = {1'b0, wofs_q} + 1'b1;
  assign pkt_word = data_wr & (state_q == PS_CMDW);
  assign pkt_last = pkt_word & (wnext >= (WO_W+1)'(PKT_WORDS));
  assign pio_word = data_rd & (state_q == PS_PIO);
  assign pio_last = pio_word & ({wnext, 1'b0} >= (WO_W+2)'(len_q));

  assign rd_ready = (state_q == PS_BUSY) & ~pkt_valid & ~cmd_wr;
  assign rd_take  = rd_ready & rd_valid;
  assign len_ext  = 16'(rd_len);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= PS_IDLE;
      status_q <= 8'h00;
      error_q  <= 8'h01;
      reason_q <= 8'h01;
      adrlo_q  <= 8'h81;
      bclo_q   <= 8'h14;
      bchi_q   <= 8'hEB;
      feat_q   <= 2'b00;
      nien_q   <= 1'b0;
      wofs_q   <= '0;
      len_q    <= '0;
    end else begin
      if (rd_take) begin
        state_q  <= PS_PIO;
        status_q <= ST_XFER;
        reason_q <= RSN_IO;
        bclo_q   <= len_ext[7:0];
        bchi_q   <= len_ext[15:8];
        len_q    <= rd_len;
        wofs_q   <= '0;
      end
      if (pio_word) begin
        wofs_q <= wnext[WO_W-1:0];
        if (pio_last) begin
          state_q  <= PS_IDLE;
          status_q <= status_q & ~ST_DRQ;
          reason_q <= RSN_DONE;
        end
      end
      if (acc_wr) begin
        unique case (host_addr)
          RA_ERRFT:  feat_q   <= host_wdata[1:0];
          RA_REASON: reason_q <= host_wdata[7:0];
          RA_ADRLO:  adrlo_q  <= host_wdata[7:0];
          RA_BCLO:   bclo_q   <= host_wdata[7:0];
          RA_BCHI:   bchi_q   <= host_wdata[7:0];
          RA_ALTCTL: nien_q   <= host_wdata[1];
          RA_DATA: begin
            if (pkt_word) begin
              wofs_q <= wnext[WO_W-1:0];
              if (pkt_last) begin
                state_q  <= PS_BUSY;
                status_q <= (status_q & ~ST_DRQ) | ST_BSY;
              end
            end
          end
          RA_STCMD: begin
            if (op_nop) begin
              state_q  <= PS_IDLE;
              status_q <= ST_ABORT;
              error_q  <= 8'h04;
            end else if (op_pkt) begin
              state_q  <= PS_CMDW;
              status_q <= ST_XFER;
              error_q  <= {6'b0, feat_q};
              reason_q <= RSN_CMD;
              wofs_q   <= '0;
            end else if (op_setft) begin
              status_q <= ST_DONE;
              error_q  <= 8'h00;
              bclo_q   <= 8'h00;
              bchi_q   <= 8'h00;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    unique case (host_addr)
      RA_DATA:   host_rdata = (state_q == PS_PIO) ? buf_rword : 16'hFFFF;
      RA_ERRFT:  host_rdata = {8'h00, error_q};
      RA_REASON: host_rdata = {8'h00, reason_q};
      RA_ADRLO:  host_rdata = {8'h00, adrlo_q};
      RA_BCLO:   host_rdata = {8'h00, bclo_q};
      RA_BCHI:   host_rdata = {8'h00, bchi_q};
      RA_STCMD,
      RA_ALTCTL: host_rdata = {8'h00, status_q};
      default:   host_rdata = 16'h0000;
    endcase
  end

  ptf_irq u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .raise   (op_nop | op_setft | rd_take | pio_last),
    .clear   (cmd_wr | (stat_rd & ~status_q[7])),
    .masked  (nien_q),
    .pending (pending),
    .irq_o   (irq)
  );

  ptf_pkt_capture #(.PKT_WORDS(PKT_WORDS), .IDX_W(WO_W)) u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (pkt_word),
    .wr_idx  (wofs_q),
    .wr_word (host_wdata),
    .launch  (pkt_last),
    .drop    (op_nop | op_pkt),
    .ready   (pkt_ready),
    .valid   (pkt_valid),
    .data    (pkt_data)
  );

  ptf_rd_buffer #(.WORDS(BUF_WORDS)) u_buf (
    .clk   (clk),
    .we    (buf_we),
    .waddr (buf_waddr),
    .wdata (buf_wdata),
    .raddr (wofs_q[AW-1:0]),
    .rdata (buf_rword)
  );
endmodule

// File: rtl/ptf_checker.sv
module ptf_checker
  import ptf_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        host_sel,
  input logic        host_wr,
  input logic [3:0]  host_addr,
  input logic [15:0] host_wdata,
  input logic [15:0] host_rdata,
  input logic        pkt_valid,
  input logic        pkt_ready,
  input logic        rd_ready,
  input ptf_state_e  state_q,
  input logic [7:0]  status_q,
  input logic        pending
);
  logic stat_rd, alt_rd, cmd_wr, data_rd;
  assign stat_rd = host_sel & ~host_wr & (host_addr == RA_STCMD);
  assign alt_rd  = host_sel & ~host_wr & (host_addr == RA_ALTCTL);
  assign cmd_wr  = host_sel &  host_wr & (host_addr == RA_STCMD);
  assign data_rd = host_sel & ~host_wr & (host_addr == RA_DATA);

  a_r5_pkt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid && !pkt_ready && !cmd_wr |=> pkt_valid);

  a_r5_rd_excl: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ready |-> !pkt_valid && state_q == PS_BUSY);

  a_r4_commit_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pkt_valid) |-> status_q == 8'hD0);

  a_r7_idle_data: assert property (@(posedge clk) disable iff (!rst_n)
    data_rd && state_q != PS_PIO |-> host_rdata == 16'hFFFF);

  a_r8_stat_clear: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd && !status_q[7] |=> !pending);

  a_r8_alt_keep: assert property (@(posedge clk) disable iff (!rst_n)
    alt_rd && pending |=> pending);

  a_r8_busy_keep: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd && status_q[7] && pending |=> pending);

  a_r10_cmd_clear: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && host_wdata[7:0] != OP_NOP && host_wdata[7:0] != OP_SETFT |=> !pending);

  a_r11_nop: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && host_wdata[7:0] == OP_NOP |=> pending && status_q == 8'h51 && !pkt_valid);
endmodule

bind pkt_taskfile_ctrl ptf_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_sel   (host_sel),
  .host_wr    (host_wr),
  .host_addr  (host_addr),
  .host_wdata (host_wdata),
  .host_rdata (host_rdata),
  .pkt_valid  (pkt_valid),
  .pkt_ready  (pkt_ready),
  .rd_ready   (rd_ready),
  .state_q    (state_q),
  .status_q   (status_q),
  .pending    (pending)
);

// File: tb/sim_pkt_taskfile_ctrl.sv
`timescale 1ns/1ps
module sim_pkt_taskfile_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_sel = 1'b0, host_wr = 1'b0;
  logic [3:0]  host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        irq, pkt_valid, rd_ready;
  logic        pkt_ready = 1'b0, rd_valid = 1'b0;
  logic [95:0] pkt_data;
  logic [8:0]  rd_len = '0;
  logic        buf_we = 1'b0;
  logic [6:0]  buf_waddr = '0;
  logic [15:0] buf_wdata = '0;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pkt_taskfile_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .irq(irq), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready), .pkt_data(pkt_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_len(rd_len),
    .buf_we(buf_we), .buf_waddr(buf_waddr), .buf_wdata(buf_wdata));

  function automatic logic [15:0] pattern(input int i);
    return 16'h3C00 ^ 16'(i * 16'h0107);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hwr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    host_sel = 1'b1; host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_sel = 1'b0; host_wr = 1'b0;
  endtask

  task automatic hrd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    host_sel = 1'b1; host_wr = 1'b0; host_addr = a;
    #2 d = host_rdata;
    @(negedge clk);
    host_sel = 1'b0;
  endtask

  task automatic fill_buf(input int words);
    for (int i = 0; i < words; i++) begin
      @(negedge clk);
      buf_we = 1'b1; buf_waddr = 7'(i); buf_wdata = pattern(i);
    end
    @(negedge clk);
    buf_we = 1'b0;
  endtask

  task automatic send_packet(input int base);
    hwr(4'd7, 16'h00A0);
    for (int k = 0; k < 6; k++) hwr(4'd0, 16'(base + k));
  endtask

  task automatic consume_packet;
    @(negedge clk); pkt_ready = 1'b1;
    @(negedge clk); pkt_ready = 1'b0;
  endtask

  task automatic start_read(input logic [8:0] len);
    bit ok;
    @(negedge clk);
    rd_valid = 1'b1; rd_len = len;
    do begin
      #2 ok = rd_ready;
      @(negedge clk);
    end while (!ok);
    rd_valid = 1'b0;
  endtask

  task automatic t_reset;
    logic [15:0] d;
    hrd(4'd3, d); chk("R1 address low", d, 16'h0081);
    hrd(4'd4, d); chk("R1 byte count low", d, 16'h0014);
    hrd(4'd5, d); chk("R1 byte count high", d, 16'h00EB);
    hrd(4'd1, d); chk("R1 error", d, 16'h0001);
    hrd(4'd2, d); chk("R1 reason", d, 16'h0001);
    hrd(4'd8, d); chk("R1 status", d, 16'h0000);
    chk("R1 irq low", irq, 0);
    hrd(4'd0, d); chk("R1 data idle", d, 16'hFFFF);
    hrd(4'd6, d); chk("R2 unmapped reads zero", d, 16'h0000);
  endtask

  task automatic t_nop_and_mask;
    logic [15:0] d;
    hwr(4'd7, 16'h0000);
    hrd(4'd8, d); chk("R11 nop status", d, 16'h0051);
    hrd(4'd1, d); chk("R11 nop error", d, 16'h0004);
    chk("R11 nop irq", irq, 1);
    hrd(4'd8, d); chk("R8 alt status keeps irq", irq, 1);
    hwr(4'd8, 16'h0002); chk("R9 mask hides irq", irq, 0);
    hwr(4'd8, 16'h0000); chk("R9 unmask shows irq", irq, 1);
    hwr(4'd7, 16'h0055); chk("R10 unknown cmd clears irq", irq, 0);
    hrd(4'd8, d); chk("R10 unknown cmd keeps status", d, 16'h0051);
    hwr(4'd7, 16'h0000); chk("R12 nop raise", irq, 1);
    hrd(4'd7, d); chk("R8 status read clears irq", irq, 0);
  endtask

  task automatic t_packet;
    logic [15:0] d;
    hwr(4'd0, 16'hDEAD);
    chk("R4 idle data write ignored", pkt_valid, 0);
    hrd(4'd8, d); chk("R4 idle data write keeps status", d, 16'h0051);
    hwr(4'd1, 16'h0003);
    hwr(4'd7, 16'h00A0);
    hrd(4'd8, d); chk("R3 packet status", d, 16'h0058);
    hrd(4'd1, d); chk("R3 error from feature", d, 16'h0003);
    hrd(4'd2, d); chk("R3 reason cmd", d, 16'h0001);
    for (int k = 0; k < 5; k++) hwr(4'd0, 16'(16'h1100 + k));
    chk("R4 not offered before sixth word", pkt_valid, 0);
    hrd(4'd8, d); chk("R4 status before sixth word", d, 16'h0058);
    hwr(4'd0, 16'h1105);
    chk("R4 offered after sixth word", pkt_valid, 1);
    hrd(4'd8, d); chk("R4 busy status", d, 16'h00D0);
    for (int k = 0; k < 6; k++) chk("R4 packet word", pkt_data[16*k +: 16], 16'(16'h1100 + k));
    chk("R5 rd_ready low while offered", rd_ready, 0);
    hrd(4'd7, d);
    repeat (3) @(negedge clk);
    chk("R5 packet held", pkt_valid, 1);
    consume_packet();
    chk("R5 packet taken", pkt_valid, 0);
    #2 chk("R5 rd_ready in busy", rd_ready, 1);
  endtask

  task automatic t_short_read;
    logic [15:0] d;
    fill_buf(128);
    start_read(9'd6);
    hrd(4'd8, d); chk("R6 read status", d, 16'h0058);
    hrd(4'd2, d); chk("R6 reason io", d, 16'h0002);
    hrd(4'd4, d); chk("R6 byte count low", d, 16'h0006);
    hrd(4'd5, d); chk("R6 byte count high", d, 16'h0000);
    chk("R6 irq", irq, 1);
    hrd(4'd7, d); chk("R8 status read clears in read", irq, 0);
    for (int i = 0; i < 3; i++) begin
      hrd(4'd0, d); chk("R7 word", d, pattern(i));
      if (i < 2) chk("R7 not yet done", irq, 0);
    end
    hrd(4'd8, d); chk("R7 end status", d, 16'h0050);
    hrd(4'd2, d); chk("R7 end reason", d, 16'h0003);
    chk("R7 end irq", irq, 1);
    hrd(4'd0, d); chk("R7 data after end", d, 16'hFFFF);
  endtask

  task automatic t_long_read_and_setft;
    logic [15:0] d;
    send_packet(16'h2200);
    consume_packet();
    start_read(9'd256);
    hrd(4'd4, d); chk("R6 long byte count low", d, 16'h0000);
    hrd(4'd5, d); chk("R6 long byte count high", d, 16'h0001);
    for (int i = 0; i < 128; i++) begin
      hrd(4'd0, d);
      if (i == 0 || i == 127) chk("R7 long word", d, pattern(i));
    end
    hrd(4'd2, d); chk("R7 long end reason", d, 16'h0003);
    hwr(4'd7, 16'h00EF);
    hrd(4'd8, d); chk("R12 setft status", d, 16'h0050);
    hrd(4'd1, d); chk("R12 setft error", d, 16'h0000);
    hrd(4'd4, d); chk("R12 byte count low", d, 16'h0000);
    hrd(4'd5, d); chk("R12 byte count high", d, 16'h0000);
    chk("R12 setft irq", irq, 1);
  endtask

  task automatic t_abort;
    logic [15:0] d;
    send_packet(16'h3300);
    consume_packet();
    start_read(9'd8);
    hrd(4'd0, d); chk("R7 first word before abort", d, pattern(0));
    hwr(4'd7, 16'h0000);
    hrd(4'd0, d); chk("R11 abort ends read", d, 16'hFFFF);
    send_packet(16'h4400);
    hwr(4'd7, 16'h0000);
    chk("R11 abort withdraws packet", pkt_valid, 0);
    #2 chk("R11 no read start after abort", rd_ready, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_nop_and_mask();
    t_packet();
    t_short_read();
    t_long_read_and_setft();
    t_abort();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule